// File: doc/BRIEF.md
# CAN Controller Interrupt Flag Register

This block is the eight-bit interrupt flag register of a small CAN controller, as the CPU bus sees it. Single-cycle event strobes from the protocol engine set sticky flags. There are three receive-buffer flags, one transmit-complete flag and three error flags. A read-only summary bit in the lowest position shows whether any error flag is standing. The block drives one interrupt request line from the seven sticky flags.

Software clears flags by writing zeros. A write leaves each flag whose data bit is 1 unchanged, so an interrupt handler can write back the one's complement of the value it read and clear exactly the events it saw. Clearing a receive flag from software also sends a one-cycle release pulse to the matching receive buffer. The buffer logic can also drop a receive flag directly through a per-buffer ready-clear strobe.

Top module: `can_irq_status`

## Requirements
- R1: After reset, rd_data reads 8'h00, irq is 0 and buf_release is 3'b000.
- R2: rx_done[n] (n = 0, 1, 2 for buffers 1, 2, 3) sets rd_data bit 5+n on the next clock, so buffer 3 is bit 7, buffer 2 is bit 6 and buffer 1 is bit 5.
- R3: tx_ok sets bit 4 (transmit complete) and tx_err sets bit 1 (transmit error) on the next clock.
- R4: Bit 3 (status change) is set on the next clock by dom_seen while run_mode is 0. While run_mode is 1 it is set by ep_change, or by rx_err when esci is 1. rx_err with esci at 0 has no effect on it.
- R5: rx_overrun sets bit 2 (overrun) on the next clock.
- R6: A write with wr_en high clears each flag in bits 7..1 whose wr_data bit is 0 and leaves each flag whose wr_data bit is 1 unchanged. Writing the complement of a read value clears exactly the flags that were set in that read.
- R7: When a set strobe and a clear (write or ready-clear) reach the same flag in the same cycle, the flag is 1 afterwards.
- R8: rdy_clr[n] clears bit 5+n on the next clock and produces no buf_release pulse.
- R9: buf_release[n] is high for exactly the one cycle after a write that cleared bit 5+n while it was set and rx_done[n] was low. It is low in every other cycle.
- R10: rd_data bit 0 reads 1 exactly when any of bits 3..1 is set. Writes to bit 0 have no effect.
- R11: irq is 1 exactly when any of bits 7..1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data; a 0 clears the flag at that position |
| rd_data | output | 8 | Flag register read value |
| rx_done | input | 3 | Per-buffer error-free reception strobes |
| rdy_clr | input | 3 | Per-buffer ready-clear strobes |
| tx_ok | input | 1 | Queued message sent successfully |
| tx_err | input | 1 | Error while sending queued message |
| run_mode | input | 1 | 1 = run mode, 0 = standby |
| dom_seen | input | 1 | Dominant bit received (used in standby) |
| ep_change | input | 1 | Error-passive status changed |
| rx_err | input | 1 | Receive error detected |
| esci | input | 1 | Lets receive errors set the status change flag |
| rx_overrun | input | 1 | Message dropped, no free buffer |
| buf_release | output | 3 | One-cycle buffer release pulses |
| irq | output | 1 | Interrupt request |

## Verification
A hardware set strobe and a software or ready-clear strobe can reach the same flag in the same clock, and the same write can also decide whether a buffer release pulse appears. The bench provokes this with directed cycles that raise rx_done, tx_ok and the error strobes together with a zeroing write or rdy_clr. It also runs a long stretch of random strobes mixed with random writes. A behavioural model computes the expected flags and release pulses every clock, with set taking priority, and the bench compares them with the outputs one nanosecond after each edge.

// File: rtl/can_irq_status.sv
module can_irq_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [2:0] rx_done,
  input  logic [2:0] rdy_clr,
  input  logic       tx_ok,
  input  logic       tx_err,
  input  logic       run_mode,
  input  logic       dom_seen,
  input  logic       ep_change,
  input  logic       rx_err,
  input  logic       esci,
  input  logic       rx_overrun,
  output logic [2:0] buf_release,
  output logic       irq
);

  logic [7:1] flags;
  logic [7:1] set_v;
  logic [7:1] clr_v;
  logic       stat_set;

  assign stat_set = run_mode ? (ep_change | (esci & rx_err)) : dom_seen;
  assign set_v    = {rx_done, tx_ok, stat_set, rx_overrun, tx_err};
  assign clr_v    = (wr_en ? ~wr_data[7:1] : 7'd0) | {rdy_clr, 4'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags       <= '0;
      buf_release <= '0;
    end else begin
      flags       <= set_v | (flags & ~clr_v);
      buf_release <= wr_en ? (~wr_data[7:5] & flags[7:5] & ~rx_done) : 3'd0;
    end
  end

  assign rd_data = {flags, |flags[3:1]};
  assign irq     = |flags;

endmodule

// File: rtl/can_irq_status_chk.sv
module can_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [2:0] rx_done,
  input logic [2:0] rdy_clr,
  input logic       tx_ok,
  input logic       rx_overrun,
  input logic [2:0] buf_release,
  input logic       irq
);

  // R2
  rx1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done[0] |=> rd_data[5]);

  // R3
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> rd_data[4]);

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rd_data[2]);

  // R6
  wr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && rd_data[4]) |=> rd_data[4]);

  // R6
  wr_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[4] && !tx_ok) |=> !rd_data[4]);

  // R8
  rdy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_clr[2] && !rx_done[2]) |=> !rd_data[7]);

  // R9
  release_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release[1] |-> ($past(rd_data[6]) && $past(wr_en)));

  // R9
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_release[0] |=> !buf_release[0] || $past(wr_en));

  // R10
  epnd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> irq);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 8'h00) |-> !irq);

endmodule

bind can_irq_status can_irq_status_chk i_can_irq_status_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .rx_done(rx_done), .rdy_clr(rdy_clr), .tx_ok(tx_ok),
  .rx_overrun(rx_overrun), .buf_release(buf_release), .irq(irq)
);

// File: tb/test_can_irq_status.sv
module test_can_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [2:0] rx_done = 3'd0, rdy_clr = 3'd0, buf_release;
  logic tx_ok = 0, tx_err = 0, run_mode = 0, dom_seen = 0, ep_change = 0;
  logic rx_err = 0, esci = 0, rx_overrun = 0, irq;

  int checks = 0, failures = 0;
  bit finished = 0;
  string phase = "R1";

  bit m_flag [8];
  bit m_rel [3];

  always #2 clk = ~clk;

  can_irq_status i_can_irq_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_done(rx_done), .rdy_clr(rdy_clr), .tx_ok(tx_ok), .tx_err(tx_err),
    .run_mode(run_mode), .dom_seen(dom_seen), .ep_change(ep_change), .rx_err(rx_err),
    .esci(esci), .rx_overrun(rx_overrun), .buf_release(buf_release), .irq(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_rd();
    int v = 0;
    for (int b = 1; b < 8; b++) if (m_flag[b]) v |= (1 << b);
    if (m_flag[1] || m_flag[2] || m_flag[3]) v |= 1;
    return v;
  endfunction

  task automatic tick();
    bit nf [8];
    bit nr [3];
    bit st;
    st = run_mode ? (ep_change || (esci && rx_err)) : dom_seen;
    for (int b = 1; b < 8; b++) begin
      bit s, c;
      case (b)
        7, 6, 5: s = rx_done[b-5];
        4: s = tx_ok;
        3: s = st;
        2: s = rx_overrun;
        default: s = tx_err;
      endcase
      c = (wr_en && !wr_data[b]) || (b >= 5 && rdy_clr[b-5]);
      nf[b] = rst_n && (s || (m_flag[b] && !c));
    end
    for (int n = 0; n < 3; n++)
      nr[n] = rst_n && wr_en && !wr_data[5+n] && m_flag[5+n] && !rx_done[n];
    @(posedge clk);
    for (int b = 1; b < 8; b++) m_flag[b] = nf[b];
    for (int n = 0; n < 3; n++) m_rel[n] = nr[n];
    #1;
    begin
      int er = model_rd();
      int erel = {29'd0, m_rel[2], m_rel[1], m_rel[0]};
      int eirq = (er & 8'hFE) != 0;
      check(rd_data[7:1] == er[7:1], phase, rd_data, er);
      check(rd_data[0] == er[0], "R10", rd_data[0], er[0]);
      check(irq == eirq[0], "R11", irq, eirq);
      check(buf_release == erel[2:0], "R9", buf_release, erel);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 8'hFF; rx_done = 0; rdy_clr = 0; tx_ok = 0; tx_err = 0;
    dom_seen = 0; ep_change = 0; rx_err = 0; rx_overrun = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (2) tick();
    rst_n = 1;
    phase = "R1";
    check(rd_data == 8'h00 && irq == 0 && buf_release == 0, "R1", rd_data, 0);
    tick();

    phase = "R2";
    for (int n = 0; n < 3; n++) begin rx_done = 3'b1 << n; tick(); end
    idle(); tick();
    phase = "R6";
    begin logic [7:0] r = rd_data; wr(~r); end
    tick();

    phase = "R3";
    tx_ok = 1; tick(); idle(); tx_err = 1; tick(); idle(); tick();
    phase = "R6"; wr(8'hEF); tick(); wr(8'hFD); tick();

    phase = "R4";
    run_mode = 0; dom_seen = 1; tick(); idle(); wr(8'hF7);
    run_mode = 1; dom_seen = 1; tick(); idle();
    ep_change = 1; tick(); idle(); wr(8'hF7);
    esci = 0; rx_err = 1; tick(); idle(); tick();
    esci = 1; rx_err = 1; tick(); idle(); wr(8'hF7);

    phase = "R5";
    rx_overrun = 1; tick(); idle(); tick();
    phase = "R10";
    wr(8'hFE); tick(); wr(8'h00); tick();

    phase = "R7";
    rx_done = 3'b111; tx_ok = 1; tx_err = 1; tick(); idle();
    rx_done = 3'b010; wr_data = 8'h00; wr_en = 1; rdy_clr = 3'b010; tx_ok = 1; tick(); idle(); tick();
    phase = "R8";
    rx_done = 3'b111; tick(); idle(); rdy_clr = 3'b101; tick(); idle(); tick();
    phase = "R9";
    wr(8'hBF); tick(); tick();

    phase = "R6";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom;
      rx_done = r[2:0] & r[10:8] & r[18:16];
      rdy_clr = r[5:3] & r[13:11] & r[21:19];
      tx_ok = r[6] & r[14]; tx_err = r[7] & r[15];
      run_mode = r[22]; dom_seen = r[23] & r[24]; ep_change = r[25] & r[26];
      rx_err = r[27]; esci = r[28]; rx_overrun = r[29] & r[30];
      wr_en = r[31] & r[1];
      wr_data = 8'($urandom);
      tick();
    end
    idle(); tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule